// File: doc/BRIEF.md
# Full-Speed USB Suspend Idle Timer

This block watches the sampled full-speed bus line state and measures how long the bus has stayed idle since the last host packet ended. A one-cycle `eop_strobe` marks the end of a packet and starts the measurement. While the line stays in the J (idle) state, a millisecond count advances. The block then raises three staged indications, each at a fixed number of milliseconds: suspend recognised, remote wakeup permitted, and the deadline by which the device must be in its low-power state.

The suspend output is active low. The time between suspend recognition and the deadline is the window in which the surrounding system stops the transceiver clock and finishes its other power-down steps. Bus activity cancels the measurement and releases every indication. Activity means a K state, an SE0 state, an invalid code, or a new end of packet. After activity, the measurement starts again only at the next end of packet.

A prescaler derives the millisecond tick from the system clock frequency. The three milestone counts are parameters. CLKS_PER_MS below means CLK_FREQ_HZ/1000. Edge E0 is the rising clock edge that samples `eop_strobe` high.

Top module: `fs_suspend_timer`

## Requirements
- R1: While `rst_n` is low, `suspend_n` is 1, and `wakeup_ok` and `deadline` are 0.
- R2: The `line_state` code 2'b01 is J, the idle state. The codes 2'b10 (K), 2'b00 (SE0) and 2'b11 (invalid) all count as bus activity.
- R3: No indication is raised before the first end of packet after reset, even when the line stays J.
- R4: With the line held at J, `suspend_n` is low from edge E0 + SUSP_MS*CLKS_PER_MS onward. Before that edge it is high.
- R5: With the line held at J, `wakeup_ok` is high from edge E0 + WAKE_MS*CLKS_PER_MS onward. Before that edge it is low.
- R6: With the line held at J, `deadline` is high from edge E0 + DEADLINE_MS*CLKS_PER_MS onward. It then stays high for as long as J lasts, because the count saturates and does not wrap.
- R7: Activity before suspend is recognised clears the measurement. No indication rises again, however long J lasts afterwards, until another end of packet arrives.
- R8: A new `eop_strobe` during a measurement restarts it. All milestones are then timed from the new edge E0.
- R9: `line_state` passes through a two-stage synchroniser. Activity driven after suspend is recognised releases `suspend_n` high and clears `wakeup_ok` and `deadline` by the third clock edge after the new code is applied.
- R10: The indications nest. `wakeup_ok` high implies `suspend_n` low, and `deadline` high implies `wakeup_ok` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_state | input | 2 | Sampled bus line code: 01 J, 10 K, 00 SE0, 11 invalid |
| eop_strobe | input | 1 | One-cycle pulse at the end of a host packet |
| suspend_n | output | 1 | Low while suspend is recognised |
| wakeup_ok | output | 1 | High while device-initiated resume is permitted |
| deadline | output | 1 | High once the suspend-entry deadline has passed |

## Verification
The assertions assume that `eop_strobe` is synchronous to `clk` and lasts one cycle, and that `line_state` changes only at the falling clock edge in the stimulus. They also assume the internal millisecond count can only advance, hold or clear.

The bench drives every input at the falling edge. It holds the line at J except where it injects activity. It places each injection so that no millisecond tick falls inside the synchroniser delay. As a result, every indication expected at each sampled cycle follows directly from the number of edges counted since E0.

// File: rtl/fs_susp_pkg.sv
package fs_susp_pkg;

   typedef enum logic [1:0] {
      LS_SE0 = 2'b00,
      LS_J   = 2'b01,
      LS_K   = 2'b10,
      LS_ERR = 2'b11
   } line_code_e;

   localparam int unsigned MS_PER_SEC = 1000;

   function automatic logic code_is_idle(input logic [1:0] code);
      return code == LS_J;
   endfunction

endpackage

// File: rtl/fs_line_sync.sv
module fs_line_sync #(
   parameter int unsigned STAGES = 2,
   parameter int unsigned WIDTH  = 2,
   parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= RESET_VAL;
            else        chain[i] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= RESET_VAL;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign dout = chain[STAGES-1];

endmodule

// File: rtl/fs_ms_prescaler.sv
module fs_ms_prescaler #(
   parameter int unsigned DIV = 48000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);

   localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

   if (DIV == 1) begin : g_bypass
      assign tick = run;
   end else begin : g_count
      logic [CW-1:0] cnt_q;
      logic          wrap;

      assign wrap = (cnt_q == CW'(DIV - 1));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     cnt_q <= '0;
         else if (!run)  cnt_q <= '0;
         else if (wrap)  cnt_q <= '0;
         else            cnt_q <= cnt_q + 1'b1;
      end

      assign tick = run && wrap;
   end

endmodule

// File: rtl/fs_idle_tracker.sv
module fs_idle_tracker #(
   parameter int unsigned DEADLINE_MS = 10,
   parameter int unsigned MS_W        = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            eop,
   input  logic            line_idle,
   input  logic            tick,
   output logic            armed,
   output logic            run,
   output logic [MS_W-1:0] ms_count
);

   localparam logic [MS_W-1:0] MS_CAP = MS_W'(DEADLINE_MS);

   logic            armed_q;
   logic [MS_W-1:0] ms_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         ms_q    <= '0;
      end else if (eop) begin
         armed_q <= 1'b1;
         ms_q    <= '0;
      end else if (armed_q && !line_idle) begin
         armed_q <= 1'b0;
         ms_q    <= '0;
      end else if (armed_q && tick && (ms_q < MS_CAP)) begin
         ms_q    <= ms_q + 1'b1;
      end
   end

   assign armed    = armed_q;
   assign run      = armed_q && line_idle && !eop;
   assign ms_count = ms_q;

endmodule

// File: rtl/fs_suspend_timer.sv
module fs_suspend_timer
   import fs_susp_pkg::*;
#(
   parameter int unsigned CLK_FREQ_HZ = 48_000_000,
   parameter int unsigned SUSP_MS     = 3,
   parameter int unsigned WAKE_MS     = 5,
   parameter int unsigned DEADLINE_MS = 10,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] line_state,
   input  logic       eop_strobe,
   output logic       suspend_n,
   output logic       wakeup_ok,
   output logic       deadline
);

   localparam int unsigned CLKS_PER_MS = CLK_FREQ_HZ / MS_PER_SEC;
   localparam int unsigned MS_W        = $clog2(DEADLINE_MS + 1);

   if (CLK_FREQ_HZ % MS_PER_SEC != 0) begin : g_bad_clk
      $error("CLK_FREQ_HZ must be a whole multiple of 1000");
   end
   if (CLKS_PER_MS < 1) begin : g_bad_div
      $error("CLK_FREQ_HZ must be at least 1000");
   end
   if (!(SUSP_MS > 0 && SUSP_MS < WAKE_MS && WAKE_MS < DEADLINE_MS)) begin : g_bad_ms
      $error("milestones must satisfy 0 < SUSP_MS < WAKE_MS < DEADLINE_MS");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [1:0]      line_sync;
   logic            line_idle;
   logic            armed;
   logic            run;
   logic            tick;
   logic [MS_W-1:0] ms_now;

   fs_line_sync #(
      .STAGES    (SYNC_STAGES),
      .WIDTH     (2),
      .RESET_VAL (LS_J)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (line_state),
      .dout  (line_sync)
   );

   assign line_idle = code_is_idle(line_sync);

   fs_ms_prescaler #(
      .DIV (CLKS_PER_MS)
   ) u_presc (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .tick  (tick)
   );

   fs_idle_tracker #(
      .DEADLINE_MS (DEADLINE_MS),
      .MS_W        (MS_W)
   ) u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .eop       (eop_strobe),
      .line_idle (line_idle),
      .tick      (tick),
      .armed     (armed),
      .run       (run),
      .ms_count  (ms_now)
   );

   assign suspend_n = !(armed && (ms_now >= MS_W'(SUSP_MS)));
   assign wakeup_ok =   armed && (ms_now >= MS_W'(WAKE_MS));
   assign deadline  =   armed && (ms_now >= MS_W'(DEADLINE_MS));

endmodule

// File: rtl/fs_suspend_timer_chk.sv
module fs_suspend_timer_chk #(
   parameter int unsigned DEADLINE_MS = 10,
   parameter int unsigned MS_W        = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            eop_strobe,
   input logic            line_idle,
   input logic [MS_W-1:0] ms_now,
   input logic            suspend_n,
   input logic            wakeup_ok,
   input logic            deadline
);

   // R6: count never passes the deadline milestone
   a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      ms_now <= MS_W'(DEADLINE_MS));

   // R6: while idle without a packet, the count holds or advances by one
   a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!eop_strobe && line_idle) |=>
         (({1'b0, ms_now} == {1'b0, $past(ms_now)}) ||
          ({1'b0, ms_now} == {1'b0, $past(ms_now)} + 1'b1)));

   // R7 / R9: synchronised activity clears the measurement
   a_r7_activity_clears: assert property (@(posedge clk) disable iff (!rst_n)
      !line_idle |=> (ms_now == '0 && suspend_n && !wakeup_ok && !deadline));

   // R8: end of packet restarts from zero
   a_r8_eop_restart: assert property (@(posedge clk) disable iff (!rst_n)
      eop_strobe |=> (ms_now == '0 && suspend_n && !wakeup_ok && !deadline));

   // R10: indications nest
   a_r10_wake_needs_susp: assert property (@(posedge clk) disable iff (!rst_n)
      wakeup_ok |-> !suspend_n);

   a_r10_deadline_needs_wake: assert property (@(posedge clk) disable iff (!rst_n)
      deadline |-> wakeup_ok);

endmodule

bind fs_suspend_timer fs_suspend_timer_chk #(
   .DEADLINE_MS (DEADLINE_MS),
   .MS_W        (MS_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .eop_strobe (eop_strobe),
   .line_idle  (line_idle),
   .ms_now     (ms_now),
   .suspend_n  (suspend_n),
   .wakeup_ok  (wakeup_ok),
   .deadline   (deadline)
);

// File: tb/tb_fs_suspend_timer.sv
module tb_fs_suspend_timer;

   localparam int DIV = 8;
   localparam int SMS = 3;
   localparam int WMS = 5;
   localparam int DMS = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] line_state = 2'b01;
   logic       eop_strobe = 1'b0;
   logic       suspend_n;
   logic       wakeup_ok;
   logic       deadline;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   fs_suspend_timer #(
      .CLK_FREQ_HZ (DIV * 1000),
      .SUSP_MS     (SMS),
      .WAKE_MS     (WMS),
      .DEADLINE_MS (DMS),
      .SYNC_STAGES (2)
   ) dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .line_state (line_state),
      .eop_strobe (eop_strobe),
      .suspend_n  (suspend_n),
      .wakeup_ok  (wakeup_ok),
      .deadline   (deadline)
   );

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic chk_ms(input string req, input int ms);
      chk(req, "suspend_n", suspend_n, !(ms >= SMS));
      chk(req, "wakeup_ok", wakeup_ok, ms >= WMS);
      chk(req, "deadline",  deadline,  ms >= DMS);
   endtask

   function automatic int ms_at(input int n);
      int m = n / DIV;
      return (m > DMS) ? DMS : m;
   endfunction

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic pulse_eop();
      eop_strobe = 1'b1;
      step();
      eop_strobe = 1'b0;
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [1:0] act_codes [3];
      act_codes[0] = 2'b10;
      act_codes[1] = 2'b00;
      act_codes[2] = 2'b11;

      // R1: reset state
      repeat (3) step();
      chk_ms("R1", 0);
      eop_strobe = 1'b1;
      step();
      chk_ms("R1", 0);
      eop_strobe = 1'b0;
      rst_n = 1'b1;
      step();

      // R3: idle J without any end of packet
      for (int n = 0; n < 60; n++) begin
         chk_ms("R3", 0);
         step();
      end

      // R4 R5 R6: full sweep after an end of packet
      pulse_eop();
      for (int n = 0; n <= (DMS + 2) * DIV; n++) begin
         chk_ms((n < WMS * DIV) ? "R4" : (n < DMS * DIV) ? "R5" : "R6", ms_at(n));
         step();
      end
      // R6: saturation, no wrap beyond the count width
      for (int n = 0; n < 200; n++) begin
         chk_ms("R6", DMS);
         step();
      end

      // R9 and R2: every activity code releases the indications
      for (int c = 0; c < 3; c++) begin
         if (c != 0) begin
            pulse_eop();
            for (int n = 0; n < DMS * DIV + 4; n++) step();
            chk_ms("R6", DMS);
         end
         line_state = act_codes[c];
         step();
         line_state = 2'b01;
         step();
         step();
         chk_ms("R9", 0);
         chk("R2", "suspend_n after non-J code", suspend_n, 1'b1);
         // R7: stays released without a new packet
         for (int n = 0; n < 40; n++) begin
            chk_ms("R7", 0);
            step();
         end
      end

      // R7: activity before recognition, at several offsets
      for (int k = 0; k < 3; k++) begin
         int off = 5 + 7 * k;
         pulse_eop();
         for (int n = 0; n < off; n++) step();
         line_state = act_codes[k];
         step();
         line_state = 2'b01;
         step();
         step();
         chk_ms("R7", 0);
         for (int n = 0; n < 6 * DIV; n++) begin
            chk_ms("R7", 0);
            step();
         end
      end

      // R8: second end of packet restarts the timing
      pulse_eop();
      for (int n = 0; n < 20; n++) step();
      chk_ms("R8", ms_at(20));
      pulse_eop();
      for (int n = 0; n <= WMS * DIV + 2; n++) begin
         chk_ms("R8", ms_at(n));
         step();
      end

      // R10: nesting at the deadline
      for (int n = 0; n < DMS * DIV; n++) step();
      chk("R10", "wake with deadline", wakeup_ok, deadline);
      chk("R10", "suspend with wake", !suspend_n, wakeup_ok);

      finish_run();
   end

endmodule